// File: doc/BRIEF.md
# Shadowed Configuration Register Controller

This block keeps a bank of 24 byte-wide configuration registers that shadow a configuration area in nonvolatile storage, next to a 64-byte user storage area. The nonvolatile array is modelled as a synchronous byte memory. Every byte write to it opens a busy window of `NV_BUSY` clock cycles. After reset, or when `reboot_i` is pulsed, the block waits `BOOT_DELAY` cycles. It then copies each configuration byte from storage into its shadow register. The host port is closed until that copy has finished.

The host reaches registers and storage through one byte-wide request channel. A request is a valid/ready transfer: `req_ready_o` is low for the whole boot copy and high at all other times. The host must hold `req_valid_i` and the request fields steady until a cycle in which ready is high. Each accepted request produces exactly one response pulse on `rsp_valid_o` in the following cycle. The response has no ready signal and cannot be stalled. Register writes take effect at once and leave storage unchanged. Storage writes reach the shadow register only at the next boot copy.

Three bits of control register 16h decide which writes are accepted. Bit 3 locks the configuration. Bit 1 inhibits user-storage writes while the reset fault input is high. Bit 0 inhibits them while the UV/OV fault input is high. Fault inputs are also readable as read-only status bytes.

Top module: `cfg_shadow_ctrl`

## Requirements
- R1: After the boot copy, shadow register k (address k, 00h..17h) holds the byte at storage address 80h+k. Storage is blank (00h) after `rst_n` and keeps its contents across `reboot_i`.
- R2: From reset release, and from the cycle after an accepted `reboot_i`, `req_ready_o` stays low and no request is accepted until `booting_o` falls.
- R3: The boot copy, delay included, finishes within `BOOT_LIMIT` cycles.
- R4: A host write to register 00h..17h changes that register at once and does not change storage address 80h+k. A read of storage address 80h+k still returns the stored byte.
- R5: While bit 3 of register 16h is 1, writes to registers 00h..17h other than 16h, and writes to storage 80h..97h other than 96h, are rejected.
- R6: While locked, a write to register 16h or storage 96h is accepted but changes only bit 3. The other bits keep their old values.
- R7: A write to user storage 40h..7Fh is rejected when register 16h bit 0 is 1 and `uvov_i` is high, or when bit 1 is 1 and `rst_flt_i` is high. Otherwise it is accepted and stored.
- R8: While `nv_busy_o` is high, every storage write is rejected. Register writes are still accepted.
- R9: Registers 0Ch and 0Dh always read 00h. Writes to 0Ch, 0Dh, 17h, 8Ch, 8Dh, 97h and to any address outside the writable map are rejected. Unmapped addresses read 00h.
- R10: Address 28h reads {2'b0, `pri_flt_i`} and 29h reads {2'b0, `sec_flt_i`}. Address 2Ah reads {`wdo_i`, 5'b0, `rst_flt_i`, `uvov_i`}. All three are read-only.
- R11: `reboot_i` reloads every shadow register from storage, discarding earlier register writes. User storage is left unchanged.
- R12: Each accepted request gives exactly one `rsp_valid_o` pulse in the next cycle. A rejected write returns `rsp_err_o`=1, leaves all state unchanged and returns data 00h. An accepted write returns `rsp_err_o`=0 and data 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears storage model and registers, starts boot |
| reboot_i | input | 1 | Software reboot command strobe |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Host request ready, low during boot copy |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | Response pulse, one cycle after acceptance |
| rsp_rdata_o | output | 8 | Read data (00h for writes) |
| rsp_err_o | output | 1 | Request rejected |
| pri_flt_i | input | 6 | Primary threshold fault flags |
| sec_flt_i | input | 6 | Secondary threshold fault flags |
| uvov_i | input | 1 | UV/OV output asserted |
| rst_flt_i | input | 1 | Reset output asserted |
| wdo_i | input | 1 | Watchdog output asserted |
| booting_o | output | 1 | Boot copy in progress |
| nv_busy_o | output | 1 | Storage write busy window |
| cfg_bank_o | output | 192 | All shadow registers, byte k at bits 8k+7:8k |

## Verification
If the lock or inhibit state is wrong inside the block, the next response pulse shows an error flag where none was expected, or the reverse. This shows up one cycle after the offending write. A wrong shadow value shows up on `cfg_bank_o` one cycle after the load or write that set it, and on the next register read. Storage corruption from a masked or busy-window write stays hidden until a later storage read, or until the next reboot copies the bad byte into the bank. For that reason the bench reads storage back and reboots after each group of storage writes.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;

  typedef enum logic [1:0] {
    BT_WAIT  = 2'd0,
    BT_COPY  = 2'd1,
    BT_DRAIN = 2'd2,
    BT_DONE  = 2'd3
  } boot_st_e;

  localparam logic [7:0] USER_BASE   = 8'h40;
  localparam logic [7:0] NV_CFG_BASE = 8'h80;
  localparam logic [7:0] FLT_BASE    = 8'h28;

  localparam int CTRL_IDX    = 22;
  localparam int LOCK_BIT    = 3;
  localparam int INH_RST_BIT = 1;
  localparam int INH_UV_BIT  = 0;

  // shadow slots that always read as zero
  function automatic bit is_blank_idx(input int i);
    return (i == 12) || (i == 13);
  endfunction

  // shadow slots the host may never write
  function automatic bit is_ro_idx(input int i);
    return is_blank_idx(i) || (i == 23);
  endfunction

endpackage

// File: rtl/cfg_nvm_array.sv
module cfg_nvm_array #(
  parameter int DEPTH       = 88,
  parameter int BUSY_CYCLES = 20,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [7:0]    wmask_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o,
  output logic          busy_o
);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      rdata_o <= 8'h00;
    end else begin
      if (we_i) mem[waddr_i] <= (mem[waddr_i] & ~wmask_i) | (wdata_i & wmask_i);
      rdata_o <= mem[raddr_i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              busy_cnt <= '0;
    else if (we_i)           busy_cnt <= CW'(BUSY_CYCLES);
    else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
  end

  assign busy_o = (busy_cnt != '0);

  // R8: the controller must never issue a write inside the busy window
  p_busy_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !we_i);

  // R8: a write always opens a busy window
  p_write_opens_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> busy_o);

endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq import cfg_shadow_pkg::*; #(
  parameter int NUM_CFG    = 24,
  parameter int DELAY      = 5,
  parameter int LIMIT      = 2500,
  localparam int IW = $clog2(NUM_CFG),
  localparam int DW = $clog2(DELAY + 1),
  localparam int LW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reboot_i,
  output logic          booting_o,
  output logic [IW-1:0] rd_idx_o,
  output logic          ld_valid_o,
  output logic [IW-1:0] ld_idx_o
);

  boot_st_e      st;
  logic [DW-1:0] dly;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= BT_WAIT;
      dly <= '0;
      idx <= '0;
    end else begin
      unique case (st)
        BT_WAIT: begin
          if (dly == DW'(DELAY - 1)) begin
            st  <= BT_COPY;
            idx <= '0;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        BT_COPY: begin
          if (idx == IW'(NUM_CFG - 1)) st <= BT_DRAIN;
          else                         idx <= idx + 1'b1;
        end
        BT_DRAIN: st <= BT_DONE;
        BT_DONE: begin
          if (reboot_i) begin
            st  <= BT_WAIT;
            dly <= '0;
          end
        end
        default: st <= BT_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid_o <= 1'b0;
      ld_idx_o   <= '0;
    end else begin
      ld_valid_o <= (st == BT_COPY);
      ld_idx_o   <= idx;
    end
  end

  assign booting_o = (st != BT_DONE);
  assign rd_idx_o  = idx;

  // R3: boot window length checked with a counter, not a long delay
  logic [LW-1:0] boot_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         boot_len <= '0;
    else if (booting_o) boot_len <= boot_len + 1'b1;
    else                boot_len <= '0;
  end

  p_boot_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    booting_o |-> (boot_len < LW'(LIMIT)));

  // R11: a reboot strobe while idle restarts the copy
  p_reboot_restarts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reboot_i && !booting_o) |=> booting_o);

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank import cfg_shadow_pkg::*; #(
  parameter int NUM_CFG = 24,
  localparam int IW = $clog2(NUM_CFG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [IW-1:0]        widx_i,
  input  logic [7:0]           wdata_i,
  input  logic [7:0]           wmask_i,
  output logic [NUM_CFG*8-1:0] bank_o
);

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_slot
    if (is_blank_idx(g)) begin : g_blank
      assign bank_o[g*8 +: 8] = 8'h00;
    end else begin : g_live
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           q <= 8'h00;
        else if (we_i && widx_i == IW'(g))    q <= (q & ~wmask_i) | (wdata_i & wmask_i);
      end
      assign bank_o[g*8 +: 8] = q;
    end
  end

endmodule

// File: rtl/cfg_shadow_ctrl.sv
module cfg_shadow_ctrl import cfg_shadow_pkg::*; #(
  parameter int NUM_CFG    = 24,
  parameter int USER_BYTES = 64,
  parameter int BOOT_DELAY = 5,
  parameter int BOOT_LIMIT = 2500,
  parameter int NV_BUSY    = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reboot_i,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_write_i,
  input  logic [7:0]           req_addr_i,
  input  logic [7:0]           req_wdata_i,
  output logic                 rsp_valid_o,
  output logic [7:0]           rsp_rdata_o,
  output logic                 rsp_err_o,
  input  logic [5:0]           pri_flt_i,
  input  logic [5:0]           sec_flt_i,
  input  logic                 uvov_i,
  input  logic                 rst_flt_i,
  input  logic                 wdo_i,
  output logic                 booting_o,
  output logic                 nv_busy_o,
  output logic [NUM_CFG*8-1:0] cfg_bank_o
);

  localparam int NV_DEPTH = USER_BYTES + NUM_CFG;
  localparam int NV_AW    = $clog2(NV_DEPTH);
  localparam int CIDX_W   = $clog2(NUM_CFG);
  localparam logic [7:0] CFG_LAST  = 8'(NUM_CFG - 1);
  localparam logic [7:0] USER_LAST = 8'(int'(USER_BASE) + USER_BYTES - 1);
  localparam logic [7:0] NCFG_LAST = 8'(int'(NV_CFG_BASE) + NUM_CFG - 1);
  localparam logic [7:0] FLT_LAST  = 8'(int'(FLT_BASE) + 2);

  // ---------------- sub-blocks ----------------
  logic [CIDX_W-1:0] boot_rd_idx, boot_ld_idx;
  logic              boot_ld_valid;
  logic [7:0]        nv_rdata;
  logic [NV_AW-1:0]  nv_raddr;
  logic              nv_we;
  logic [NV_AW-1:0]  nv_waddr;
  logic [7:0]        nv_wmask;
  logic              bank_we;
  logic [CIDX_W-1:0] bank_widx;
  logic [7:0]        bank_wdata, bank_wmask;

  cfg_boot_seq #(.NUM_CFG(NUM_CFG), .DELAY(BOOT_DELAY), .LIMIT(BOOT_LIMIT)) u_boot (
    .clk        (clk),
    .rst_n      (rst_n),
    .reboot_i   (reboot_i),
    .booting_o  (booting_o),
    .rd_idx_o   (boot_rd_idx),
    .ld_valid_o (boot_ld_valid),
    .ld_idx_o   (boot_ld_idx)
  );

  cfg_nvm_array #(.DEPTH(NV_DEPTH), .BUSY_CYCLES(NV_BUSY)) u_nvm (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (nv_we),
    .waddr_i (nv_waddr),
    .wdata_i (req_wdata_i),
    .wmask_i (nv_wmask),
    .raddr_i (nv_raddr),
    .rdata_o (nv_rdata),
    .busy_o  (nv_busy_o)
  );

  cfg_reg_bank #(.NUM_CFG(NUM_CFG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (bank_we),
    .widx_i  (bank_widx),
    .wdata_i (bank_wdata),
    .wmask_i (bank_wmask),
    .bank_o  (cfg_bank_o)
  );

  logic [7:0] cfg_arr [NUM_CFG];
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_unpack
    assign cfg_arr[g] = cfg_bank_o[g*8 +: 8];
  end

  // ---------------- request decode ----------------
  logic              acc;
  logic              is_reg, is_user, is_ncfg, is_flt;
  logic [CIDX_W-1:0] cidx;
  logic [7:0]        ctrl, cmask, reg_rd;
  logic              locked, inhibit, ro;
  logic              reg_wr_ok, ncfg_wr_ok, user_wr_ok, wr_ok;
  logic [NV_AW-1:0]  host_nv_idx;

  assign req_ready_o = !booting_o;
  assign acc         = req_valid_i && req_ready_o;
  assign ctrl        = cfg_arr[CTRL_IDX];
  assign locked      = ctrl[LOCK_BIT];
  assign inhibit     = (ctrl[INH_RST_BIT] && rst_flt_i) || (ctrl[INH_UV_BIT] && uvov_i);

  always_comb begin
    is_reg  = (req_addr_i <= CFG_LAST);
    is_user = (req_addr_i >= USER_BASE) && (req_addr_i <= USER_LAST);
    is_ncfg = (req_addr_i >= NV_CFG_BASE) && (req_addr_i <= NCFG_LAST);
    is_flt  = (req_addr_i >= FLT_BASE) && (req_addr_i <= FLT_LAST);
    cidx    = is_ncfg ? CIDX_W'(req_addr_i - NV_CFG_BASE) : CIDX_W'(req_addr_i);
    ro      = is_ro_idx(int'(cidx));
    if (!locked)                      cmask = 8'hFF;
    else if (cidx == CIDX_W'(CTRL_IDX)) cmask = 8'h01 << LOCK_BIT;
    else                              cmask = 8'h00;
    reg_wr_ok  = is_reg  && !ro && (cmask != 8'h00);
    ncfg_wr_ok = is_ncfg && !ro && (cmask != 8'h00) && !nv_busy_o;
    user_wr_ok = is_user && !inhibit && !nv_busy_o;
    wr_ok      = reg_wr_ok || ncfg_wr_ok || user_wr_ok;
    host_nv_idx = is_user ? NV_AW'(req_addr_i - USER_BASE)
                          : NV_AW'(USER_BYTES) + NV_AW'(cidx);
    reg_rd = 8'h00;
    if (is_reg && !is_blank_idx(int'(cidx))) begin
      reg_rd = cfg_arr[cidx];
    end else if (is_flt) begin
      unique case (req_addr_i - FLT_BASE)
        8'd0:    reg_rd = {2'b00, pri_flt_i};
        8'd1:    reg_rd = {2'b00, sec_flt_i};
        default: reg_rd = {wdo_i, 5'b00000, rst_flt_i, uvov_i};
      endcase
    end
  end

  // ---------------- write and read steering ----------------
  always_comb begin
    nv_we    = acc && req_write_i && (ncfg_wr_ok || user_wr_ok);
    nv_waddr = host_nv_idx;
    nv_wmask = is_ncfg ? cmask : 8'hFF;
    nv_raddr = booting_o ? NV_AW'(USER_BYTES) + NV_AW'(boot_rd_idx) : host_nv_idx;
    if (boot_ld_valid) begin
      bank_we    = 1'b1;
      bank_widx  = boot_ld_idx;
      bank_wdata = nv_rdata;
      bank_wmask = 8'hFF;
    end else begin
      bank_we    = acc && req_write_i && reg_wr_ok;
      bank_widx  = cidx;
      bank_wdata = req_wdata_i;
      bank_wmask = cmask;
    end
  end

  // ---------------- response ----------------
  logic       rsp_from_nv;
  logic [7:0] rsp_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_from_nv <= 1'b0;
      rsp_hold    <= 8'h00;
    end else begin
      rsp_valid_o <= acc;
      rsp_err_o   <= acc && req_write_i && !wr_ok;
      rsp_from_nv <= acc && !req_write_i && (is_user || is_ncfg);
      rsp_hold    <= (acc && !req_write_i) ? reg_rd : 8'h00;
    end
  end

  assign rsp_rdata_o = rsp_from_nv ? nv_rdata : rsp_hold;

  // ---------------- assertions ----------------
  p_rsp_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid_o);

  p_rsp_no_spurious_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid_o);

  p_reboot_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reboot_i && !booting_o) |=> !req_ready_o);

  // R5: while locked and idle, no shadow byte except the control byte moves
  logic [NUM_CFG*8-1:0] bank_no_ctrl;
  always_comb begin
    bank_no_ctrl = cfg_bank_o;
    bank_no_ctrl[CTRL_IDX*8 +: 8] = 8'h00;
  end

  p_lock_freezes_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !booting_o) |=> $stable(bank_no_ctrl));

  p_lock_rejects_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write_i && is_reg && locked && cidx != CIDX_W'(CTRL_IDX)) |=> rsp_err_o);

  p_inhibit_uv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write_i && is_user && uvov_i && ctrl[INH_UV_BIT]) |=> rsp_err_o);

  p_busy_rejects_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write_i && (is_user || is_ncfg) && nv_busy_o) |=> rsp_err_o);

  p_err_only_on_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write_i) |=> !rsp_err_o);

endmodule

// File: tb/cfg_shadow_ctrl_tb.sv
module cfg_shadow_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reboot_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [7:0]  req_addr_i = 8'h00;
  logic [7:0]  req_wdata_i = 8'h00;
  logic        rsp_valid_o;
  logic [7:0]  rsp_rdata_o;
  logic        rsp_err_o;
  logic [5:0]  pri_flt_i = 6'h00;
  logic [5:0]  sec_flt_i = 6'h00;
  logic        uvov_i = 1'b0;
  logic        rst_flt_i = 1'b0;
  logic        wdo_i = 1'b0;
  logic        booting_o;
  logic        nv_busy_o;
  logic [191:0] cfg_bank_o;

  always #4 clk = ~clk;

  cfg_shadow_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reboot_i(reboot_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_write_i(req_write_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .rsp_err_o(rsp_err_o),
    .pri_flt_i(pri_flt_i), .sec_flt_i(sec_flt_i), .uvov_i(uvov_i),
    .rst_flt_i(rst_flt_i), .wdo_i(wdo_i),
    .booting_o(booting_o), .nv_busy_o(nv_busy_o), .cfg_bank_o(cfg_bank_o)
  );

  int n_vec = 0;
  int n_bad = 0;

  logic [7:0] exp_d_q [$];
  logic       exp_e_q [$];
  string      exp_t_q [$];

  task automatic check(input logic [191:0] act, input logic [191:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every response pulse
  always @(negedge clk) begin
    if (rst_n && rsp_valid_o) begin
      if (exp_d_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R12 unexpected response: actual %0h expected none", rsp_rdata_o);
      end else begin
        logic [7:0] ed;
        logic       ee;
        string      et;
        ed = exp_d_q.pop_front();
        ee = exp_e_q.pop_front();
        et = exp_t_q.pop_front();
        n_vec++;
        if (rsp_rdata_o !== ed || rsp_err_o !== ee) begin
          n_bad++;
          $display("FAIL %s: actual data %0h err %0b expected data %0h err %0b",
                   et, rsp_rdata_o, rsp_err_o, ed, ee);
        end
      end
    end
  end

  // driver: called at a falling edge, returns at a falling edge
  task automatic xfer(input logic wr, input logic [7:0] addr, input logic [7:0] wd,
                      input logic [7:0] exp_d, input logic exp_e, input string tag);
    exp_d_q.push_back(exp_d);
    exp_e_q.push_back(exp_e);
    exp_t_q.push_back(tag);
    req_valid_i = 1'b1;
    req_write_i = wr;
    req_addr_i  = addr;
    req_wdata_i = wd;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic wr_ok(input logic [7:0] a, input logic [7:0] d, input string t);
    xfer(1'b1, a, d, 8'h00, 1'b0, t);
  endtask
  task automatic wr_bad(input logic [7:0] a, input logic [7:0] d, input string t);
    xfer(1'b1, a, d, 8'h00, 1'b1, t);
  endtask
  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    xfer(1'b0, a, 8'h00, e, 1'b0, t);
  endtask
  task automatic wait_boot();
    while (booting_o) @(negedge clk);
  endtask
  task automatic wait_nv();
    @(negedge clk);
    while (nv_busy_o) @(negedge clk);
  endtask
  task automatic reboot();
    reboot_i = 1'b1;
    @(negedge clk);
    reboot_i = 1'b0;
    check({191'b0, req_ready_o}, 192'd0, "R2 ready low after reboot");
    wait_boot();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({190'b0, booting_o, req_ready_o}, 192'd2, "R2 reset: booting, not ready");
    check({191'b0, rsp_valid_o}, 192'd0, "R12 reset: no response");
    wait_boot();
    check(cfg_bank_o, 192'd0, "R1 blank storage loads zeros");

    // storage writes and busy window
    wr_ok (8'h80, 8'h11, "R4 storage write 80h");
    wr_bad(8'h85, 8'h55, "R8 storage write during busy");
    wr_ok (8'h01, 8'h22, "R8 register write during busy");
    wait_nv();
    wr_ok (8'h40, 8'hA5, "R7 user write, no inhibit");
    wait_nv();
    rd(8'h80, 8'h11, "R4 storage readback 80h");
    rd(8'h85, 8'h00, "R8 rejected write left 85h");
    rd(8'h00, 8'h00, "R4 storage write leaves register");
    rd(8'h01, 8'h22, "R4 register write immediate");
    rd(8'h81, 8'h00, "R4 register write leaves storage");

    // reboot reloads, keeps user storage
    reboot();
    rd(8'h00, 8'h11, "R1 reload from 80h");
    rd(8'h01, 8'h00, "R11 volatile edit discarded");
    rd(8'h40, 8'hA5, "R11 user storage kept");

    // unused and read-only
    wr_bad(8'h0C, 8'h5A, "R9 write 0Ch");
    rd(8'h0C, 8'h00, "R9 read 0Ch");
    wr_bad(8'h17, 8'h5A, "R9 write 17h");
    wr_bad(8'h97, 8'h5A, "R9 write 97h");
    rd(8'h20, 8'h00, "R9 unmapped reads zero");

    // fault status
    pri_flt_i = 6'h2A; sec_flt_i = 6'h15; uvov_i = 1'b1; rst_flt_i = 1'b1; wdo_i = 1'b1;
    rd(8'h28, 8'h2A, "R10 primary faults");
    rd(8'h29, 8'h15, "R10 secondary faults");
    rd(8'h2A, 8'h83, "R10 status byte");
    wr_bad(8'h28, 8'hFF, "R10 fault reg read-only");

    // user storage inhibits
    wr_ok(8'h16, 8'h03, "R7 enable both inhibits");
    rst_flt_i = 1'b0;
    wr_bad(8'h41, 8'h3C, "R7 inhibit on UV/OV");
    uvov_i = 1'b0; rst_flt_i = 1'b1;
    wr_bad(8'h41, 8'h3C, "R7 inhibit on reset");
    wr_ok(8'h16, 8'h01, "R7 only UV/OV inhibit");
    wr_ok(8'h41, 8'h3C, "R7 reset ignored when bit1 clear");
    wait_nv();
    rd(8'h41, 8'h3C, "R7 user byte stored");
    rst_flt_i = 1'b0;

    // lock
    wr_ok(8'h16, 8'h0B, "R5 set lock");
    wr_bad(8'h00, 8'h77, "R5 locked register write");
    rd(8'h00, 8'h11, "R5 register unchanged");
    wr_bad(8'h80, 8'h77, "R5 locked storage write");
    wait_nv();
    rd(8'h80, 8'h11, "R5 storage unchanged");
    wr_ok(8'h16, 8'hF4, "R6 locked write to control");
    rd(8'h16, 8'h03, "R6 only lock bit changed");
    wr_ok(8'h00, 8'h77, "R6 unlocked write accepted");
    rd(8'h00, 8'h77, "R6 unlocked value");

    // storage lock bit exception
    wr_ok(8'h16, 8'h08, "R5 relock");
    wr_ok(8'h96, 8'hFF, "R6 locked write to 96h");
    wait_nv();
    rd(8'h96, 8'h08, "R6 storage 96h only lock bit");
    reboot();
    rd(8'h16, 8'h08, "R11 lock restored from storage");
    rd(8'h00, 8'h11, "R11 register 00h reloaded");
    wr_bad(8'h02, 8'h01, "R5 locked after reboot");
    check(cfg_bank_o[22*8 +: 8], 192'h08, "R1 bank byte 16h");

    repeat (3) @(negedge clk);
    check(exp_d_q.size(), 192'd0, "R12 all responses seen");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule